// File: doc/BRIEF.md
# Bit-Serial Array Processing Cell

This block is a single processing element of a large two-dimensional cellular array. Each element keeps nine one-bit storage cells. One of them is a self cell. The other eight are plane cells, one for each bit plane of the array. All control lines are broadcast, so every element in the array performs the same micro-operation in the same cycle, each on its own data.

The input side forms one bit from the element's neighbours. Each neighbour bit, and the element's own self cell, has its own gate. The gated bits are ORed together. The result can then be inverted or passed unchanged. That bit is written on the next clock edge into every storage cell whose write enable is set.

The output side reads any chosen set of storage cells in either true or inverted polarity. It ORs the values read and can invert the result. Together with the input inversion, one pass can form a sum of literals or, through De Morgan, a product of literals. Neighbour bits arrive on ports, and the array wiring around the element lies outside it.

Top module: `bitcell_top`

## Requirements
- R1: After a synchronous active-high reset, all nine storage cells hold 0.
- R2: The input bit is the OR of (gate AND bit) over every neighbour and over the self cell. When `in_pass_i` is 0 this OR is inverted; when it is 1 it is used unchanged.
- R3: On a rising clock edge, the input bit is loaded into every cell whose `wr_en_i` bit is set. Cell indices 0 to 7 are the planes and index 8 is the self cell. Cells whose write enable is clear keep their value.
- R4: When `rd_true_i` is 1, read-selected cells contribute their stored value. When it is 0, they contribute the inverted value.
- R5: `out_o` is the OR of the contributions of all cells whose `rd_en_i` bit is set. When `out_pass_i` is 0 this OR is inverted; when it is 1 it is driven unchanged.
- R6: With no read enable set, the OR is 0, so `out_o` equals the inverse of `out_pass_i`.
- R7: A cell that is both write-enabled and read-enabled in the same cycle is not written, and `conflict_o` is 1 in that cycle. Other write-enabled cells are still written. With no such overlap, `conflict_o` is 0.
- R8: `out_o` and `conflict_o` are combinational from the current storage contents and controls. A value written at an edge is visible on `out_o` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nbr_i | input | NNBR | Neighbour bits |
| gate_nbr_i | input | NNBR | Per-neighbour gate enables |
| gate_self_i | input | 1 | Gate enable for the self cell on the input OR |
| in_pass_i | input | 1 | 1 passes the input OR, 0 inverts it |
| wr_en_i | input | NPLANE+1 | Write enables; bit 8 is the self cell |
| rd_true_i | input | 1 | 1 reads true values, 0 reads inverted values |
| rd_en_i | input | NPLANE+1 | Read enables; bit 8 is the self cell |
| out_pass_i | input | 1 | 1 passes the output OR, 0 inverts it |
| out_o | output | 1 | Result of the output path |
| conflict_o | output | 1 | A cell is selected for both write and read |

## Verification
Writing and reading can meet in one cycle. The self cell can also feed the input OR while being rewritten, and a plane can be read and write-enabled at the same time. The bench provokes a same-cell write/read overlap and judges it on `out_o` and `conflict_o` in that cycle. It then reads the clashing cell and a cleanly written neighbour plane on the following cycles. A randomized run mixes such overlaps with ordinary passes, and each result is compared against a shadow model of the nine cells.

// File: rtl/bitcell_pkg.sv
package bitcell_pkg;

    localparam int unsigned NBR_DEFAULT   = 8;
    localparam int unsigned PLANE_DEFAULT = 8;

    typedef enum logic {
        POL_INVERT = 1'b0,
        POL_PASS   = 1'b1
    } pol_e;

    function automatic logic apply_pol(input logic v, input pol_e p);
        return (p == POL_PASS) ? v : ~v;
    endfunction

endpackage

// File: rtl/cell_gather.sv
module cell_gather
    import bitcell_pkg::*;
#(
    parameter int unsigned NNBR = NBR_DEFAULT
) (
    input  logic [NNBR-1:0] nbr_i,
    input  logic [NNBR-1:0] gate_nbr_i,
    input  logic            self_bit_i,
    input  logic            gate_self_i,
    input  pol_e            pol_i,
    output logic            din_o
);
    logic any_hit;

    always_comb begin
        any_hit = |(nbr_i & gate_nbr_i) | (self_bit_i & gate_self_i);
        din_o   = apply_pol(any_hit, pol_i);
    end
endmodule

// File: rtl/cell_store.sv
module cell_store #(
    parameter int unsigned NCELL = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din_i,
    input  logic [NCELL-1:0] wr_en_i,
    input  logic [NCELL-1:0] rd_en_i,
    output logic [NCELL-1:0] store_o,
    output logic             conflict_o
);
    logic [NCELL-1:0] clash;
    logic [NCELL-1:0] cell_q;

    assign clash = wr_en_i & rd_en_i;

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q[c] <= 1'b0;
            end else if (wr_en_i[c] && !clash[c]) begin
                cell_q[c] <= din_i;
            end
        end
    end

    assign store_o    = cell_q;
    assign conflict_o = |clash;
endmodule

// File: rtl/cell_emit.sv
module cell_emit
    import bitcell_pkg::*;
#(
    parameter int unsigned NCELL = 9
) (
    input  logic [NCELL-1:0] store_i,
    input  logic [NCELL-1:0] rd_en_i,
    input  pol_e             rd_pol_i,
    input  pol_e             out_pol_i,
    output logic             out_o
);
    logic [NCELL-1:0] lit;
    logic             sum;

    for (genvar c = 0; c < NCELL; c++) begin : g_lit
        assign lit[c] = rd_en_i[c] & apply_pol(store_i[c], rd_pol_i);
    end

    always_comb begin
        sum   = |lit;
        out_o = apply_pol(sum, out_pol_i);
    end
endmodule

// File: rtl/bitcell_top.sv
module bitcell_top
    import bitcell_pkg::*;
#(
    parameter int unsigned NNBR   = NBR_DEFAULT,
    parameter int unsigned NPLANE = PLANE_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NNBR-1:0]   nbr_i,
    input  logic [NNBR-1:0]   gate_nbr_i,
    input  logic              gate_self_i,
    input  logic              in_pass_i,
    input  logic [NPLANE:0]   wr_en_i,
    input  logic              rd_true_i,
    input  logic [NPLANE:0]   rd_en_i,
    input  logic              out_pass_i,
    output logic              out_o,
    output logic              conflict_o
);
    localparam int unsigned NCELL    = NPLANE + 1;
    localparam int unsigned SELF_IDX = NPLANE;

    logic [NCELL-1:0] store_q;
    logic             din;
    pol_e             in_pol, rd_pol, out_pol;

    assign in_pol  = pol_e'(in_pass_i);
    assign rd_pol  = pol_e'(rd_true_i);
    assign out_pol = pol_e'(out_pass_i);

    cell_gather #(.NNBR(NNBR)) u_gather (
        .nbr_i       (nbr_i),
        .gate_nbr_i  (gate_nbr_i),
        .self_bit_i  (store_q[SELF_IDX]),
        .gate_self_i (gate_self_i),
        .pol_i       (in_pol),
        .din_o       (din)
    );

    cell_store #(.NCELL(NCELL)) u_store (
        .clk        (clk),
        .rst        (rst),
        .din_i      (din),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .store_o    (store_q),
        .conflict_o (conflict_o)
    );

    cell_emit #(.NCELL(NCELL)) u_emit (
        .store_i   (store_q),
        .rd_en_i   (rd_en_i),
        .rd_pol_i  (rd_pol),
        .out_pol_i (out_pol),
        .out_o     (out_o)
    );
endmodule

// File: rtl/bitcell_chk.sv
module bitcell_chk #(
    parameter int unsigned NNBR   = 8,
    parameter int unsigned NPLANE = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [NNBR-1:0] nbr_i,
    input logic [NNBR-1:0] gate_nbr_i,
    input logic            gate_self_i,
    input logic            in_pass_i,
    input logic [NPLANE:0] wr_en_i,
    input logic            rd_true_i,
    input logic [NPLANE:0] rd_en_i,
    input logic            out_pass_i,
    input logic            out_o,
    input logic            conflict_o,
    input logic [NPLANE:0] store_q
);
    logic din_ref;
    always_comb begin
        din_ref = |(nbr_i & gate_nbr_i) | (gate_self_i & store_q[NPLANE]);
        if (!in_pass_i) din_ref = ~din_ref;
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> store_q == '0);

    a_r6_empty_read: assert property (@(posedge clk) disable iff (rst)
        rd_en_i == '0 |-> out_o == !out_pass_i);

    a_r5_true_hit: assert property (@(posedge clk) disable iff (rst)
        (rd_true_i && out_pass_i && (rd_en_i & store_q) != '0) |-> out_o);

    a_r7_flag_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i & rd_en_i) == '0 |-> !conflict_o);

    for (genvar c = 0; c <= NPLANE; c++) begin : g_cellchk
        a_r3_write_loads: assert property (@(posedge clk) disable iff (rst)
            (wr_en_i[c] && !rd_en_i[c]) |=> store_q[c] == $past(din_ref));
        a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
            !wr_en_i[c] |=> $stable(store_q[c]));
        a_r7_clash_holds: assert property (@(posedge clk) disable iff (rst)
            (wr_en_i[c] && rd_en_i[c]) |=> $stable(store_q[c]));
    end
endmodule

bind bitcell_top bitcell_chk #(.NNBR(NNBR), .NPLANE(NPLANE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .nbr_i      (nbr_i),
    .gate_nbr_i (gate_nbr_i),
    .gate_self_i(gate_self_i),
    .in_pass_i  (in_pass_i),
    .wr_en_i    (wr_en_i),
    .rd_true_i  (rd_true_i),
    .rd_en_i    (rd_en_i),
    .out_pass_i (out_pass_i),
    .out_o      (out_o),
    .conflict_o (conflict_o),
    .store_q    (store_q)
);

// File: tb/test_bitcell_top.sv
`timescale 1ns/1ps
module test_bitcell_top;
    localparam int NNBR   = 8;
    localparam int NPLANE = 8;
    localparam int NCELL  = NPLANE + 1;

    typedef struct {
        logic  exp_out;
        logic  exp_conf;
        string tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NNBR-1:0]  nbr_i = '0, gate_nbr_i = '0;
    logic             gate_self_i = 1'b0, in_pass_i = 1'b1;
    logic [NPLANE:0]  wr_en_i = '0, rd_en_i = '0;
    logic             rd_true_i = 1'b1, out_pass_i = 1'b1;
    logic             out_o, conflict_o;

    item_t            sb_q[$];
    logic [NCELL-1:0] model = '0;
    int               total = 0, bad = 0;
    bit               done = 1'b0;

    always #5 clk = ~clk;

    bitcell_top #(.NNBR(NNBR), .NPLANE(NPLANE)) i_bitcell_top (
        .clk(clk), .rst(rst), .nbr_i(nbr_i), .gate_nbr_i(gate_nbr_i),
        .gate_self_i(gate_self_i), .in_pass_i(in_pass_i), .wr_en_i(wr_en_i),
        .rd_true_i(rd_true_i), .rd_en_i(rd_en_i), .out_pass_i(out_pass_i),
        .out_o(out_o), .conflict_o(conflict_o)
    );

    task automatic op(input logic [NNBR-1:0] nb, input logic [NNBR-1:0] gn,
                      input logic gs, input logic ip, input logic [NPLANE:0] wr,
                      input logic rt, input logic [NPLANE:0] rd, input logic opass,
                      input string tag);
        logic  din, sum;
        item_t it;
        @(negedge clk);
        nbr_i = nb; gate_nbr_i = gn; gate_self_i = gs; in_pass_i = ip;
        wr_en_i = wr; rd_true_i = rt; rd_en_i = rd; out_pass_i = opass;
        din = |(nb & gn) | (gs & model[NPLANE]);
        if (!ip) din = ~din;
        sum = |(rd & (rt ? model : ~model));
        it.exp_out  = opass ? sum : ~sum;
        it.exp_conf = |(wr & rd);
        it.tag      = tag;
        sb_q.push_back(it);
        for (int c = 0; c < NCELL; c++)
            if (wr[c] && !rd[c]) model[c] = din;
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                total++;
                if (out_o !== it.exp_out) begin
                    bad++;
                    $display("FAIL %s out_o actual=%b expected=%b", it.tag, out_o, it.exp_out);
                end
                total++;
                if (conflict_o !== it.exp_conf) begin
                    bad++;
                    $display("FAIL %s conflict_o actual=%b expected=%b", it.tag, conflict_o, it.exp_conf);
                end
            end
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        op('0, '0, 0, 1, '0, 1, 9'h1FF, 1, "R1 all cells zero true read");
        op('0, '0, 0, 1, '0, 0, 9'h1FF, 1, "R1/R4 all cells zero inverted read");
        op('0, '0, 0, 1, '0, 1, '0, 0, "R6 empty read inverted");
        op('0, '0, 0, 1, '0, 1, '0, 1, "R6 empty read passed");
        op(8'h04, 8'h04, 0, 1, 9'h028, 1, '0, 1, "R2/R3 write neighbour hit");
        op('0, '0, 0, 1, '0, 1, 9'h008, 1, "R3 R8 plane3 written");
        op('0, '0, 0, 1, '0, 1, 9'h020, 1, "R3 plane5 written");
        op('0, '0, 0, 1, '0, 1, 9'h010, 1, "R3 plane4 untouched");
        op(8'hFF, 8'h00, 0, 0, 9'h100, 1, '0, 1, "R2 inverted empty OR to self");
        op('0, '0, 0, 1, '0, 1, 9'h100, 1, "R2 self cell now one");
        op('0, '0, 1, 0, 9'h001, 1, '0, 1, "R2 self gated inverted into plane0");
        op('0, '0, 0, 1, '0, 1, 9'h001, 1, "R2 plane0 true read");
        op('0, '0, 0, 1, '0, 0, 9'h001, 1, "R4 plane0 inverted read");
        op('0, '0, 0, 1, '0, 1, 9'h008, 0, "R5 output inverted");
        op('0, '0, 0, 1, '0, 0, 9'h018, 0, "R5 product of literals");
        op(8'h80, 8'h80, 0, 1, 9'h050, 0, 9'h010, 1, "R7 clash on plane4");
        op('0, '0, 0, 1, '0, 1, 9'h010, 1, "R7 plane4 not written");
        op('0, '0, 0, 1, '0, 1, 9'h040, 1, "R7 plane6 written");
        op(8'h01, 8'h01, 0, 1, 9'h080, 1, 9'h004, 1, "R8 write plane7 read plane2");
        op('0, '0, 0, 1, '0, 1, 9'h080, 1, "R8 plane7 visible after edge");
        for (int k = 0; k < 80; k++)
            op(NNBR'($urandom), NNBR'($urandom), 1'($urandom), 1'($urandom),
               NCELL'($urandom), 1'($urandom), NCELL'($urandom), 1'($urandom),
               "R2/R3/R4/R5/R7 mixed");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule